// File: doc/BRIEF.md
# Oversampled Serial Receive Channel

This block turns an asynchronous serial line into a queue of tagged characters. A free-running divider produces an oversampling tick every (rate+1) clock cycles, and fourteen ticks make one bit period. The receiver locks onto a falling edge, confirms the start bit at mid-bit, samples eight data bits least significant first and then the stop bit. Each completed character goes into a 64-deep queue together with two tags: one for a bad stop bit and one for a break.

Software or a bus adapter reads one word per read strobe. The word always carries a validity marker, so a read of an empty queue is harmless. The block also reports the number of queued characters and three conditions: a fill threshold reached, a period of silence with data waiting, and a framing error or overrun. The last two are one-cycle pulses.

Top module: `uart_rx_os`

## Requirements
- R1: One bit period lasts (rate_i+1)*14 clock cycles. Each bit is sampled at its middle. Data is received least significant bit first and appears in bits 7:0 of the read word. Frames are 8 data bits, no parity and 1 stop bit.
- R2: A low pulse that is shorter than half a bit and high again at the start bit's mid-point stores no character.
- R3: Up to 64 characters are kept in arrival order. level_o gives the count as 8 bits, and empty_o is high exactly when the count is 0.
- R4: rd_word_o shows the oldest character, and a cycle with rd_i high removes it. When the queue is empty, bit 8 of the word is 1 and bits 7:0 are 0. A read then removes nothing.
- R5: A character whose stop bit is low and whose data is nonzero is stored with bit 9 set. It also produces a one-cycle pulse on fe_o.
- R6: A frame whose data and stop bit are all low stores exactly one word with bit 10 set, bit 9 clear and data 0, and gives no fe_o pulse. After any frame with a low stop bit, the receiver starts no new frame until the line has returned high.
- R7: A character completed while 64 are held is dropped and produces a one-cycle pulse on ovr_o. The queue contents are unchanged.
- R8: trig_o is high when level_o is at or above the threshold chosen by trig_sel_i: 0 selects 1, 1 selects 4, 2 selects 8, 3 selects 16, 4 selects 32, and 5 to 7 select 48.
- R9: tmo_sel_i selects the silence limit: 0 disables it, 1 selects 4 character times, 2 selects 8 and 3 selects 16. One character time is 140 ticks. tmo_o rises once the queue has been non-empty with no store and no read for that limit. A store or a read restarts the count.
- R10: After reset the queue is empty, level_o is 0 and all event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| rate_i | input | 8 | Tick divider value |
| trig_sel_i | input | 3 | Fill threshold code |
| tmo_sel_i | input | 2 | Silence limit code |
| rd_i | input | 1 | Read strobe, removes oldest word |
| rd_word_o | output | 11 | {break, error, empty, data[7:0]} |
| level_o | output | 8 | Number of queued characters |
| empty_o | output | 1 | Queue empty |
| trig_o | output | 1 | Fill threshold reached |
| tmo_o | output | 1 | Silence limit reached with data queued |
| fe_o | output | 1 | Framing error pulse |
| ovr_o | output | 1 | Overrun pulse |

## Verification
A character is stored at the middle of its stop bit. The level and tags then appear one register later, about half a bit before the frame ends. The bench therefore checks level, threshold and read word only after the whole frame plus one idle bit time, which covers any tick phase. The fe_o and ovr_o pulses last one cycle, one edge after the store, so negedge counters collect them and the bench compares the counts. The silence flag is due 560 ticks after the last store at code 1, so it is checked clearly before that point and clearly after it.

// File: rtl/uart_rx_os.sv
module uart_rx_os #(
  parameter int DEPTH = 64,
  parameter int OSR   = 14,
  parameter int DBITS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_i,
  input  logic [7:0]  rate_i,
  input  logic [2:0]  trig_sel_i,
  input  logic [1:0]  tmo_sel_i,
  input  logic        rd_i,
  output logic [10:0] rd_word_o,
  output logic [7:0]  level_o,
  output logic        empty_o,
  output logic        trig_o,
  output logic        tmo_o,
  output logic        fe_o,
  output logic        ovr_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int SW = $clog2(OSR);
  localparam int BW = $clog2(DBITS);
  localparam int MID = OSR / 2 - 1;
  localparam int CHAR_TICKS = (DBITS + 2) * OSR;
  localparam int TW = $clog2(CHAR_TICKS);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_HOLD} st_t;

  logic rx_m, rx_s;
  logic [7:0] div_q;
  logic tick;
  st_t st_q;
  logic [SW-1:0] sub_q;
  logic [BW-1:0] bit_q;
  logic [DBITS-1:0] sh_q;

  logic [DBITS+1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic full, push, do_wr, do_rd, bad_stop, is_brk;

  logic [TW-1:0] ct_q;
  logic [4:0] ch_q;
  logic [7:0] thr;
  logic [4:0] lim;

  assign tick = (div_q >= rate_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m  <= 1'b1;
      rx_s  <= 1'b1;
      div_q <= '0;
    end else begin
      rx_m  <= rx_i;
      rx_s  <= rx_m;
      div_q <= tick ? 8'd0 : div_q + 8'd1;
    end
  end

  assign push     = (st_q == S_STOP) && tick && (sub_q == SW'(OSR - 1));
  assign bad_stop = !rx_s;
  assign is_brk   = bad_stop && (sh_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign empty_o  = (cnt_q == '0);
  assign do_wr    = push && !full;
  assign do_rd    = rd_i && !empty_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      sub_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          sub_q <= '0;
          bit_q <= '0;
          if (!rx_s) st_q <= S_START;
        end
        S_START: if (tick) begin
          if (sub_q == SW'(MID)) begin
            sub_q <= '0;
            st_q  <= rx_s ? S_IDLE : S_DATA;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        S_DATA: if (tick) begin
          if (sub_q == SW'(OSR - 1)) begin
            sub_q <= '0;
            sh_q  <= {rx_s, sh_q[DBITS-1:1]};
            bit_q <= bit_q + 1'b1;
            if (bit_q == BW'(DBITS - 1)) st_q <= S_STOP;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        S_STOP: if (tick) begin
          if (sub_q == SW'(OSR - 1)) begin
            sub_q <= '0;
            st_q  <= bad_stop ? S_HOLD : S_IDLE;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        S_HOLD: if (rx_s) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= {is_brk, bad_stop && !is_brk, sh_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      fe_o  <= 1'b0;
      ovr_o <= 1'b0;
    end else begin
      if (do_wr) wp_q <= wp_q + 1'b1;
      if (do_rd) rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_wr) - CW'(do_rd);
      fe_o  <= push && bad_stop && !is_brk;
      ovr_o <= push && full;
    end
  end

  assign rd_word_o = empty_o ? 11'h100
                             : {mem[rp_q][DBITS+1], mem[rp_q][DBITS], 1'b0, mem[rp_q][DBITS-1:0]};
  assign level_o = 8'(cnt_q);

  always_comb begin
    case (trig_sel_i)
      3'd0:    thr = 8'd1;
      3'd1:    thr = 8'd4;
      3'd2:    thr = 8'd8;
      3'd3:    thr = 8'd16;
      3'd4:    thr = 8'd32;
      default: thr = 8'd48;
    endcase
  end
  assign trig_o = (level_o >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ct_q <= '0;
      ch_q <= '0;
    end else if (do_wr || do_rd || empty_o) begin
      ct_q <= '0;
      ch_q <= '0;
    end else if (tick) begin
      if (ct_q == TW'(CHAR_TICKS - 1)) begin
        ct_q <= '0;
        if (ch_q != 5'd31) ch_q <= ch_q + 5'd1;
      end else begin
        ct_q <= ct_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (tmo_sel_i)
      2'd1:    lim = 5'd4;
      2'd2:    lim = 5'd8;
      default: lim = 5'd16;
    endcase
  end
  assign tmo_o = (tmo_sel_i != 2'd0) && !empty_o && (ch_q >= lim);
endmodule

// File: rtl/uart_rx_os_chk.sv
module uart_rx_os_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_i,
  input logic [10:0] rd_word_o,
  input logic [7:0]  level_o,
  input logic        empty_o,
  input logic        trig_o,
  input logic        tmo_o,
  input logic        ovr_o
);
  p_level_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= 8'd64);

  p_level_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, level_o} <= {1'b0, $past(level_o)} + 9'd1) &&
    ({1'b0, level_o} + 9'd1 >= {1'b0, $past(level_o)}));

  p_empty_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> (rd_word_o[8] && rd_word_o[7:0] == 8'd0));

  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && rd_i) |=> (level_o <= 8'd1));

  p_ovr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> $past(level_o) == 8'd64);

  p_trig_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> !empty_o);

  p_tmo_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> !empty_o);
endmodule

bind uart_rx_os uart_rx_os_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .rd_word_o(rd_word_o),
  .level_o(level_o), .empty_o(empty_o), .trig_o(trig_o),
  .tmo_o(tmo_o), .ovr_o(ovr_o)
);

// File: tb/uart_rx_os_tb.sv
`timescale 1ns/1ps
module uart_rx_os_tb;
  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, rd = 1'b0;
  logic [7:0] rate = 8'd0;
  logic [2:0] tsel = 3'd0;
  logic [1:0] msel = 2'd0;
  logic [10:0] word;
  logic [7:0] level;
  logic empty, trig, tmo, fe, ovr;
  int errors = 0, checks = 0, fe_cnt = 0, ovr_cnt = 0;
  logic [10:0] q [0:255];
  int qh = 0, qt = 0;

  always #2 clk = ~clk;

  uart_rx_os u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .rate_i(rate), .trig_sel_i(tsel),
    .tmo_sel_i(msel), .rd_i(rd), .rd_word_o(word), .level_o(level),
    .empty_o(empty), .trig_o(trig), .tmo_o(tmo), .fe_o(fe), .ovr_o(ovr)
  );

  always @(negedge clk) begin
    if (fe) fe_cnt++;
    if (ovr) ovr_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int thr_of(input logic [2:0] s);
    case (s)
      3'd0: return 1; 3'd1: return 4; 3'd2: return 8;
      3'd3: return 16; 3'd4: return 32; default: return 48;
    endcase
  endfunction

  task automatic hold(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stopb, input int extra_low);
    int bc = (int'(rate) + 1) * 14;
    hold(1'b0, bc);
    for (int i = 0; i < 8; i++) hold(b[i], bc);
    hold(stopb, bc);
    if (extra_low > 0) hold(1'b0, extra_low * bc);
    hold(1'b1, bc);
  endtask

  task automatic pop(output logic [10:0] w);
    @(negedge clk);
    w = word;
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pop_check(input string req);
    logic [10:0] w;
    pop(w);
    check(req, w, q[qh]);
    qh++;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [10:0] w;
    int base;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 empty", empty, 1);
    check("R10 level", level, 0);
    check("R10 trig", trig, 0);
    check("R10 tmo", tmo, 0);
    check("R4 empty word", word, 11'h100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 basic frame at rate 0 and rate 3
    send(8'hA5, 1'b1, 0);
    q[qt++] = 11'h0A5;
    check("R1 level after frame", level, 1);
    check("R3 not empty", empty, 0);
    rate = 8'd3;
    send(8'h3C, 1'b1, 0);
    q[qt++] = 11'h03C;
    check("R3 level two", level, 2);
    pop_check("R1 first byte");
    pop_check("R1 slow byte");
    check("R3 empty after drain", empty, 1);

    // R4 read of empty queue removes nothing
    pop(w);
    check("R4 empty read word", w, 11'h100);
    check("R4 level stays 0", level, 0);

    // R2 glitch shorter than half a bit
    rate = 8'd0;
    hold(1'b0, 4);
    hold(1'b1, 60);
    check("R2 glitch ignored", level, 0);

    // R5 framing error
    base = fe_cnt;
    send(8'h5A, 1'b0, 0);
    q[qt++] = 11'h25A;
    check("R5 fe pulse count", fe_cnt - base, 1);
    pop_check("R5 error tag");

    // R6 break
    base = fe_cnt;
    send(8'h00, 1'b0, 3);
    q[qt++] = 11'h400;
    check("R6 one word stored", level, 1);
    check("R6 no fe pulse", fe_cnt - base, 0);
    pop_check("R6 break tag");

    // R9 timeout
    msel = 2'd1;
    tsel = 3'd5;
    send(8'h11, 1'b1, 0);
    q[qt++] = 11'h011;
    repeat (400) @(negedge clk);
    check("R9 tmo not yet", tmo, 0);
    repeat (220) @(negedge clk);
    check("R9 tmo raised", tmo, 1);
    check("R8 below 48", trig, 0);
    pop_check("R9 byte");
    check("R9 tmo cleared", tmo, 0);
    msel = 2'd0;

    // R7 overrun, R8 threshold at full
    for (int i = 0; i < 64; i++) begin
      send(8'(i + 3), 1'b1, 0);
      q[qt++] = 11'(i + 3);
    end
    check("R3 full level", level, 64);
    check("R8 trig at 48", trig, 1);
    base = ovr_cnt;
    send(8'hEE, 1'b1, 0);
    check("R7 ovr pulse", ovr_cnt - base, 1);
    check("R7 level unchanged", level, 64);
    for (int i = 0; i < 64; i++) pop_check("R7 order kept");
    pop(w);
    check("R7 dropped byte absent", w, 11'h100);

    // Random stream: R1 R3 R8
    for (int n = 0; n < 24; n++) begin
      logic [7:0] b;
      rate = 8'($urandom_range(0, 2));
      tsel = 3'($urandom_range(0, 7));
      b = 8'($urandom);
      send(b, 1'b1, 0);
      q[qt++] = {3'b000, b};
      check("R3 random level", level, qt - qh);
      check("R8 random trig", trig, ((qt - qh) >= thr_of(tsel)) ? 1 : 0);
      if (n % 6 == 5) begin
        pop_check("R1 random data");
        pop_check("R1 random data");
      end
    end
    while (qh < qt) pop_check("R4 drain");
    check("R3 final empty", empty, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule